// File: doc/BRIEF.md
# Two-Wire Memory Slave Write Front End

This block is the receive side of a two-wire serial slave that sits in front of a small byte-addressed memory. A fast system clock samples the serial clock and data lines through synchronizers. The block finds start and stop conditions on the bus and assembles the device-select byte and the word-address byte. It answers the master by pulling the data line low through an open-drain enable. Each received data byte is handed to a page write buffer together with its target address. When a write session closes cleanly, the block requests the internal programming cycle.

The block has two behaviours that let the rest of the memory subsystem stay simple. First, while the memory reports a programming cycle in progress, the block leaves its own select byte unanswered, so a master can poll with select bytes until one is acknowledged. Second, the write-protect input is sampled once, on the serial clock falling edge that closes the word-address acknowledge slot. If protect is high at that instant, the first data byte is not acknowledged and the whole session is dropped.

Read transfers beyond acknowledging the select byte, and the storage array itself, belong to other blocks.

Top module: `i2c_mem_slave`

## Requirements
- R1: The engine ignores the bus until it detects a start condition (data falling while clock is high). Bytes clocked before any start get no acknowledge and produce no buffer write.
- R2: After a start, a select byte whose upper seven bits equal the device identity (default 1010000) and whose least significant bit is 0 (write) is acknowledged. The pull-low output rises after the clock falling edge that follows the eighth bit and releases at the falling edge that ends the ninth clock.
- R3: A select byte with any other identity is not acknowledged, and every further byte up to the next start or stop is also left unanswered.
- R4: While the busy input is high at the decision edge, a matching select byte is not acknowledged.
- R5: After an acknowledged write select, the word-address byte is acknowledged. Each following data byte is acknowledged and presented on the buffer port with a one-cycle write strobe, its data byte and its target address.
- R6: The target address starts at the received word address and advances by one after each data byte. Only the low log2(PAGE_BYTES) bits (default 4) count, so the address wraps inside its page.
- R7: Write protect is sampled at the falling clock edge that ends the word-address acknowledge slot. If it is high, the first data byte gets no acknowledge, no buffer write and no commit, and the rest of the session is ignored.
- R8: Changes on write protect after that sampling edge have no effect on the session.
- R9: A stop condition that ends a write session with at least one accepted data byte raises the commit output for one cycle. A stop after a session with no accepted data byte gives no commit.
- R10: A repeated start restarts select-byte reception and discards the pending session, so the commit requires a stop after accepted data within the same session.
- R11: A matching select byte with the read bit set is acknowledged. After that the line stays released, later bytes are ignored, and no commit follows.
- R12: The pull-low output never changes while the synchronized clock is high, and it is never asserted during the eight data bit slots of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired, includes own pull) |
| writeProtect | input | 1 | High blocks write sessions when sampled |
| wrBusy | input | 1 | Internal programming cycle in progress |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| bufWrEn | output | 1 | One-cycle strobe for a received data byte |
| bufAddr | output | ADDR_W | Target address of the data byte |
| bufData | output | 8 | Received data byte |
| wrCommit | output | 1 | One-cycle request to start the programming cycle |

## Verification
On every cycle the assertions check that the pull-low enable holds still while the clock is high. They check that buffer strobes and commit pulses last one cycle and never coincide, that a commit is only issued in a session that delivered data, and that no select acknowledge begins while busy is high. The acknowledge pattern, the address wrap inside a page, the single write-protect sampling instant and the effect of repeated starts, reads and mismatched identities depend on whole transactions. Only the bench's scenarios show them, where a behavioural model predicts every acknowledge bit and every buffer write.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } engState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic loadAddr;
    logic incAddr;
    logic sampleWp;
    logic setPull;
    logic clrPull;
  } ctlStrobe_t;

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2cmem_datapath.sv
module i2cmem_datapath
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_BYTES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  input  ctlStrobe_t        strobe,
  output logic              sclLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteFull,
  output logic              wpLatched,
  output logic              sdaPullLow,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] wordAddr
);

  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int BYTE_BITS = 8;
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic sclSync, sdaSync, wpSync;
  logic sclPrev, sdaPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [ADDR_W-1:0] nextAddr;

  i2cmem_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn, wpIn}),
    .dout ({sclSync, sdaSync, wpSync})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclLevel = sclSync;
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign byteFull = (bitCnt == CNT_W'(BYTE_BITS));

  // Bit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (strobe.clrBits) begin
      bitCnt <= '0;
    end else if (strobe.shiftIn) begin
      rxByte <= {rxByte[6:0], sdaSync};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Page-wrapping address increment
  generate
    if (PAGE_BITS < ADDR_W) begin : g_page_wrap
      assign nextAddr = {wordAddr[ADDR_W-1:PAGE_BITS], wordAddr[PAGE_BITS-1:0] + 1'b1};
    end else begin : g_flat_wrap
      assign nextAddr = wordAddr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordAddr <= '0;
    else if (strobe.loadAddr) wordAddr <= ADDR_W'(rxByte);
    else if (strobe.incAddr)  wordAddr <= nextAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wpLatched <= 1'b0;
    else if (strobe.sampleWp) wpLatched <= wpSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sdaPullLow <= 1'b0;
    else if (strobe.clrPull) sdaPullLow <= 1'b0;
    else if (strobe.setPull) sdaPullLow <= 1'b1;
  end

endmodule

// File: rtl/i2cmem_ctl.sv
module i2cmem_ctl
  import i2cmem_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       byteFull,
  input  logic       wpLatched,
  input  logic       wrBusy,
  input  logic [7:0] rxByte,
  output ctlStrobe_t strobe,
  output logic       bufWrEn,
  output logic       wrCommit,
  output engState_t  state
);

  engState_t stateNext;
  logic readMode, readNext;
  logic writeOk, okNext;
  logic receiving;
  logic closeByte;

  assign receiving = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_DATA);
  assign closeByte = sclFall && byteFull;

  always_comb begin
    strobe    = '0;
    bufWrEn   = 1'b0;
    wrCommit  = 1'b0;
    stateNext = state;
    readNext  = readMode;
    okNext    = writeOk;
    if (startDet) begin
      stateNext      = ST_DEV;
      strobe.clrBits = 1'b1;
      strobe.clrPull = 1'b1;
      okNext         = 1'b0;
    end else if (stopDet) begin
      wrCommit       = writeOk;
      stateNext      = ST_IDLE;
      strobe.clrPull = 1'b1;
      okNext         = 1'b0;
    end else begin
      strobe.shiftIn = receiving && sclRise && !byteFull;
      case (state)
        ST_DEV: if (closeByte) begin
          if (rxByte[7:1] == DEV_ID && !wrBusy) begin
            strobe.setPull = 1'b1;
            readNext       = rxByte[0];
            stateNext      = ST_DEV_ACK;
          end else begin
            stateNext = ST_SKIP;
          end
        end
        ST_DEV_ACK: if (sclFall) begin
          strobe.clrPull = 1'b1;
          strobe.clrBits = 1'b1;
          stateNext      = readMode ? ST_SKIP : ST_WADDR;
        end
        ST_WADDR: if (closeByte) begin
          strobe.setPull  = 1'b1;
          strobe.loadAddr = 1'b1;
          stateNext       = ST_WADDR_ACK;
        end
        ST_WADDR_ACK: if (sclFall) begin
          strobe.clrPull  = 1'b1;
          strobe.clrBits  = 1'b1;
          strobe.sampleWp = 1'b1;
          stateNext       = ST_DATA;
        end
        ST_DATA: if (closeByte) begin
          if (wpLatched) begin
            stateNext = ST_SKIP;
          end else begin
            strobe.setPull = 1'b1;
            bufWrEn        = 1'b1;
            okNext         = 1'b1;
            stateNext      = ST_DATA_ACK;
          end
        end
        ST_DATA_ACK: if (sclFall) begin
          strobe.clrPull = 1'b1;
          strobe.clrBits = 1'b1;
          strobe.incAddr = 1'b1;
          stateNext      = ST_DATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      readMode <= 1'b0;
      writeOk  <= 1'b0;
    end else begin
      state    <= stateNext;
      readMode <= readNext;
      writeOk  <= okNext;
    end
  end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_BYTES = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              writeProtect,
  input  logic              wrBusy,
  output logic              sdaPullLow,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        bufData,
  output logic              wrCommit
);

  ctlStrobe_t strobe;
  engState_t  state;
  logic sclLevel, sclRise, sclFall, startDet, stopDet, byteFull, wpLatched;

  i2cmem_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .wpIn       (writeProtect),
    .strobe     (strobe),
    .sclLevel   (sclLevel),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .startDet   (startDet),
    .stopDet    (stopDet),
    .byteFull   (byteFull),
    .wpLatched  (wpLatched),
    .sdaPullLow (sdaPullLow),
    .rxByte     (bufData),
    .wordAddr   (bufAddr)
  );

  i2cmem_ctl #(.DEV_ID(DEV_ID)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .byteFull  (byteFull),
    .wpLatched (wpLatched),
    .wrBusy    (wrBusy),
    .rxByte    (bufData),
    .strobe    (strobe),
    .bufWrEn   (bufWrEn),
    .wrCommit  (wrCommit),
    .state     (state)
  );

endmodule

// File: rtl/i2cmem_checker.sv
module i2cmem_checker
  import i2cmem_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclLevel,
  input logic      startDet,
  input logic      sdaPullLow,
  input logic      bufWrEn,
  input logic      wrCommit,
  input logic      wrBusy,
  input engState_t state
);

  logic sclSeen;
  logic dataSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSeen  <= 1'b1;
      dataSeen <= 1'b0;
    end else begin
      sclSeen <= sclLevel;
      if (startDet)     dataSeen <= 1'b0;
      else if (bufWrEn) dataSeen <= 1'b1;
    end
  end

  AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && sclSeen) |-> $stable(sdaPullLow)); // R12

  AST_BUF_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> !bufWrEn); // R5

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit); // R9

  AST_COMMIT_NOT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> !bufWrEn); // R9

  AST_COMMIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> dataSeen); // R10

  AST_BUSY_NO_ADDR_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullLow) && state == ST_DEV_ACK) |-> !$past(wrBusy)); // R4

endmodule

bind i2c_mem_slave i2cmem_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclLevel   (sclLevel),
  .startDet   (startDet),
  .sdaPullLow (sdaPullLow),
  .bufWrEn    (bufWrEn),
  .wrCommit   (wrCommit),
  .wrBusy     (wrBusy),
  .state      (state)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;

  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclDrv, sdaDrv, wp, busy;
  logic sdaPullLow, bufWrEn, wrCommit;
  logic [7:0] bufAddr, bufData;
  logic sdaLine;
  assign sdaLine = sdaDrv & ~sdaPullLow;

  i2c_mem_slave i_i2c_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .writeProtect(wp), .wrBusy(busy), .sdaPullLow(sdaPullLow),
    .bufWrEn(bufWrEn), .bufAddr(bufAddr), .bufData(bufData), .wrCommit(wrCommit)
  );

  int errors = 0;
  int checks = 0;
  int commits = 0;
  logic [15:0] expQ[$];
  logic [15:0] expHead;
  bit stray;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model side: expected buffer writes queued by scenarios
  always @(negedge clk) begin
    if (rstN) begin
      if (bufWrEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected buffer write", {bufAddr, bufData}, 0);
        end else begin
          expHead = expQ.pop_front();
          check({bufAddr, bufData} == expHead, "R5 R6 buffer write", {bufAddr, bufData}, expHead);
        end
      end
      if (wrCommit) commits++;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    sdaDrv = b;
    waitN(Q);
    sclDrv = 1'b1;
    waitN(Q / 2);
    stray |= sdaPullLow;
    waitN(Q / 2);
    sclDrv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit got;
    stray = 1'b0;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaDrv = 1'b1;
    waitN(Q);
    sclDrv = 1'b1;
    waitN(Q / 2);
    got = ~sdaLine;
    check(got == expAck, {req, " ack"}, got, expAck);
    waitN(Q / 2);
    sclDrv = 1'b0;
    check(!stray, "R12 no pull during data bits", stray, 0);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1;
    waitN(Q);
    sclDrv = 1'b1;
    waitN(Q);
    sdaDrv = 1'b0;
    waitN(Q);
    sclDrv = 1'b0;
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0;
    waitN(Q);
    sclDrv = 1'b1;
    waitN(Q);
    sdaDrv = 1'b1;
    waitN(Q);
  endtask

  task automatic expectCommits(input int n, input string req);
    waitN(4);
    check(commits == n, req, commits, n);
    check(expQ.size() == 0, {req, " pending writes"}, expQ.size(), 0);
  endtask

  function automatic logic [7:0] pageStep(input logic [7:0] a, input int k);
    logic [3:0] low;
    low = a[3:0] + 4'(k);
    return {a[7:4], low};
  endfunction

  initial begin
    rstN = 1'b0; sclDrv = 1'b1; sdaDrv = 1'b1; wp = 1'b0; busy = 1'b0;
    waitN(5);
    check(sdaPullLow == 1'b0 && bufWrEn == 1'b0 && wrCommit == 1'b0, "R1 reset state",
          {sdaPullLow, bufWrEn, wrCommit}, 0);
    rstN = 1'b1;
    waitN(5);

    // R1: traffic before any start is ignored
    sdaDrv = 1'b1; waitN(Q); sclDrv = 1'b0;
    sendByte(8'hA0, 1'b0, "R1 select before start");
    sendByte(8'h12, 1'b0, "R1 data before start");
    stopCond();
    expectCommits(0, "R1 no commit before start");

    // R2 R5 R9: single byte write
    expQ.push_back({8'h35, 8'h5A});
    startCond();
    sendByte(8'hA0, 1'b1, "R2 write select");
    sendByte(8'h35, 1'b1, "R5 word address");
    sendByte(8'h5A, 1'b1, "R5 data byte");
    stopCond();
    expectCommits(1, "R9 commit after byte write");

    // R6: page write wrapping inside a 16-byte page
    for (int k = 0; k < 4; k++) expQ.push_back({pageStep(8'h1E, k), 8'hC0 + 8'(k)});
    startCond();
    sendByte(8'hA0, 1'b1, "R2 write select");
    sendByte(8'h1E, 1'b1, "R5 word address");
    for (int k = 0; k < 4; k++) sendByte(8'hC0 + 8'(k), 1'b1, "R6 page data");
    stopCond();
    expectCommits(2, "R9 commit after page write");

    // R3: identity mismatch
    startCond();
    sendByte(8'hA2, 1'b0, "R3 wrong identity");
    sendByte(8'h00, 1'b0, "R3 following byte");
    stopCond();
    expectCommits(2, "R3 no commit");

    // R4: busy polling
    busy = 1'b1;
    startCond();
    sendByte(8'hA0, 1'b0, "R4 select while busy");
    stopCond();
    expectCommits(2, "R4 no commit");
    busy = 1'b0;
    startCond();
    sendByte(8'hA0, 1'b1, "R4 select after busy");
    stopCond();
    expectCommits(2, "R9 no commit without data");

    // R7: write protect high at the sampling edge
    wp = 1'b1;
    startCond();
    sendByte(8'hA0, 1'b1, "R2 write select");
    sendByte(8'h40, 1'b1, "R5 word address");
    sendByte(8'h11, 1'b0, "R7 protected first data");
    sendByte(8'h22, 1'b0, "R7 protected later data");
    stopCond();
    expectCommits(2, "R7 no commit when protected");
    wp = 1'b0;

    // R8: protect rises after the sampling edge
    expQ.push_back({8'h48, 8'h33});
    startCond();
    sendByte(8'hA0, 1'b1, "R2 write select");
    sendByte(8'h48, 1'b1, "R5 word address");
    waitN(Q);
    wp = 1'b1;
    sendByte(8'h33, 1'b1, "R8 late protect ignored");
    stopCond();
    expectCommits(3, "R8 commit despite late protect");
    wp = 1'b0;

    // R10: repeated start discards the pending session
    expQ.push_back({8'h50, 8'h77});
    startCond();
    sendByte(8'hA0, 1'b1, "R2 write select");
    sendByte(8'h50, 1'b1, "R5 word address");
    sendByte(8'h77, 1'b1, "R5 data byte");
    startCond();
    sendByte(8'hA0, 1'b1, "R10 select after repeated start");
    sendByte(8'h60, 1'b1, "R10 word address");
    stopCond();
    expectCommits(3, "R10 repeated start discards session");

    // R11: read select
    startCond();
    sendByte(8'hA1, 1'b1, "R11 read select");
    sendByte(8'h00, 1'b0, "R11 bytes ignored after read");
    stopCond();
    expectCommits(3, "R11 no commit after read");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule